// File: doc/BRIEF.md
# Embedded-Clock Frame Deserializer

This block turns a serial bit stream into 10-bit parallel words. The transmitter wraps every word in a 12-bit frame. A marker bit of value 1 goes first. The ten payload bits follow, least-significant first. A closing bit of value 0 ends the frame. That fixed 1/0 pair is the only thing the receiver can use to find where frames begin. A one-cycle enable, `bit_en`, marks each clock cycle that carries a new serial bit. One frame therefore spans twelve enabled cycles.

While it searches, the block tests one candidate bit offset at a time. After repeated matches at the same offset it reports lock on an active-low status pin. It then presents each received payload together with a recovered word strobe. The user chooses which edge of that strobe marks new data. If lock is missing or the block is powered down, the data and strobe pins float at high impedance, so several receivers can share one bus.

Top module: `frame_deser`

## Requirements
- R1: Frame layout: the first serial bit of a frame is the marker (1), the next ten bits are payload bit 0 through bit 9, and the twelfth bit is the closing bit (0). While locked, `dout` shows the payload of a frame from the clock edge that samples that frame's closing bit.
- R2: `lock_n` goes low on the edge that samples the closing bit of the 8th consecutive conforming frame at one offset. After 7 frames plus 11 bits it is still high.
- R3: During the search, a nonconforming candidate moves the test point by one bit. Lock is found after exactly 8 frames, whatever number (0 to 11) of idle zero bits comes before the first frame.
- R4: Lock is lost only after 4 consecutive nonconforming frames. A conforming frame resets that count, and the search then restarts.
- R5: Whenever `lock_n` is high, `dout` and `wclk` are at high impedance. This includes after reset.
- R6: While locked, a nonconforming frame leaves `dout` holding the last conforming payload.
- R7: With `rise_sel`=1, `wclk` goes high on the same edge that updates `dout`. It stays high for the first 5 bits of the next frame and goes low on the 6th. With `rise_sel`=0 the waveform is inverted.
- R8: `wake` low is powerdown. From the next clock the block is unlocked and floating, and it acquires nothing while `wake` stays low.
- R9: On cycles with `bit_en` low, `ser_in` is ignored and no internal state advances.
- R10: The search begins only after a transition has been seen on `ser_in`. A constant input never produces lock.
- R11: After lock is lost, 8 conforming frames bring lock back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wake | input | 1 | Low holds the block in powerdown |
| bit_en | input | 1 | High in each cycle that carries a serial bit |
| ser_in | input | 1 | Serial data bit |
| rise_sel | input | 1 | 1: data referenced to the rising strobe edge; 0: to the falling edge |
| dout | output | 10 | Parallel payload, high impedance when unlocked |
| wclk | output | 1 | Recovered word strobe, high impedance when unlocked |
| lock_n | output | 1 | Low while frame alignment is held |

## Verification
Lock, the new `dout` word and the strobe's active edge all change on the edge that samples a closing bit. The bench therefore samples these outputs at the falling clock edge right after sending that bit. The strobe's return edge is due on the 6th bit of the following frame, so the bench checks the strobe after the 5th bit and again after the 6th. Powerdown takes effect one clock after `wake` falls. Loss of lock is checked after the 3rd and after the 4th bad frame.

// File: rtl/frame_deser_pkg.sv
package frame_deser_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_LOCK} align_st_t;
endpackage

// File: rtl/frame_window.sv
// Sliding window over the most recent FR_W serial bits, plus detection of the first transition.
module frame_window #(
  parameter int FR_W = 12
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            bit_en,
  input  logic            ser_in,
  output logic [FR_W-1:0] win_nxt,
  output logic            active
);
  logic [FR_W-1:0] win_q;
  logic            last_q;
  logic            act_q;

  // The oldest bit lands at index 0 and the newest at the top.
  assign win_nxt = {ser_in, win_q[FR_W-1:1]};
  assign active  = act_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      win_q  <= '0;
      last_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (bit_en) begin
      win_q  <= win_nxt;
      last_q <= ser_in;
      if (ser_in != last_q) act_q <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_align.sv
// Alignment search and lock tracking.
module frame_align
  import frame_deser_pkg::*;
#(
  parameter int FR_W        = 12,
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_FRAMES = 4
) (
  input  logic clk,
  input  logic clr,
  input  logic bit_en,
  input  logic active,
  input  logic frame_ok,
  output logic locked,
  output logic load,
  output logic half_pt
);
  localparam int CW   = $clog2(FR_W);
  localparam int GW   = $clog2(LOCK_FRAMES + 1);
  localparam int BW   = $clog2(LOSS_FRAMES + 1);
  localparam int HALF = FR_W / 2 - 1;

  align_st_t       st_q;
  logic [CW-1:0]   pos_q;
  logic [GW-1:0]   good_q;
  logic [BW-1:0]   bad_q;
  logic            at_end;

  assign at_end  = (pos_q == CW'(FR_W - 1));
  assign locked  = (st_q == ST_LOCK);
  assign load    = bit_en && at_end && frame_ok &&
                   ((st_q == ST_LOCK) ||
                    ((st_q == ST_HUNT) && (good_q == GW'(LOCK_FRAMES - 1))));
  assign half_pt = bit_en && (st_q == ST_LOCK) && (pos_q == CW'(HALF));

  always_ff @(posedge clk) begin
    if (clr) begin
      st_q   <= ST_IDLE;
      pos_q  <= CW'(FR_W - 1);
      good_q <= '0;
      bad_q  <= '0;
    end else if (bit_en) begin
      case (st_q)
        ST_IDLE: if (active) st_q <= ST_HUNT;
        ST_HUNT: begin
          if (at_end) begin
            if (frame_ok) begin
              pos_q <= '0;
              if (good_q == GW'(LOCK_FRAMES - 1)) begin
                st_q   <= ST_LOCK;
                good_q <= '0;
                bad_q  <= '0;
              end else begin
                good_q <= good_q + 1'b1;
              end
            end else begin
              // Stay at the last position so the next bit is tested: the offset moves by one.
              good_q <= '0;
            end
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        ST_LOCK: begin
          if (at_end) begin
            pos_q <= '0;
            if (frame_ok) begin
              bad_q <= '0;
            end else if (bad_q == BW'(LOSS_FRAMES - 1)) begin
              st_q   <= ST_HUNT;
              pos_q  <= CW'(FR_W - 1);
              bad_q  <= '0;
              good_q <= '0;
            end else begin
              bad_q <= bad_q + 1'b1;
            end
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strobe_gen.sv
// Recovered word strobe with selectable active edge.
module strobe_gen (
  input  logic clk,
  input  logic clr,
  input  logic load,
  input  logic half_pt,
  input  logic rise_sel,
  output logic wclk_q
);
  logic ph_q;
  logic ph_nxt;

  assign ph_nxt = load ? 1'b1 : (half_pt ? 1'b0 : ph_q);

  always_ff @(posedge clk) begin
    if (clr) begin
      ph_q   <= 1'b0;
      wclk_q <= ~rise_sel;
    end else begin
      ph_q   <= ph_nxt;
      wclk_q <= rise_sel ? ph_nxt : ~ph_nxt;
    end
  end
endmodule

// File: rtl/frame_deser.sv
module frame_deser #(
  parameter int PAY_W       = 10,
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_FRAMES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake,
  input  logic             bit_en,
  input  logic             ser_in,
  input  logic             rise_sel,
  output logic [PAY_W-1:0] dout,
  output logic             wclk,
  output logic             lock_n
);
  localparam int FR_W = PAY_W + 2;

  logic             clr;
  logic [FR_W-1:0]  win_nxt;
  logic             active;
  logic             frame_ok;
  logic             locked;
  logic             load;
  logic             half_pt;
  logic             wclk_q;
  logic [PAY_W-1:0] dout_q;

  assign clr      = rst | ~wake;
  assign frame_ok = win_nxt[0] & ~win_nxt[FR_W-1];

  frame_window #(.FR_W(FR_W)) u_win (
    .clk(clk), .clr(clr), .bit_en(bit_en), .ser_in(ser_in),
    .win_nxt(win_nxt), .active(active)
  );

  frame_align #(.FR_W(FR_W), .LOCK_FRAMES(LOCK_FRAMES), .LOSS_FRAMES(LOSS_FRAMES)) u_align (
    .clk(clk), .clr(clr), .bit_en(bit_en), .active(active), .frame_ok(frame_ok),
    .locked(locked), .load(load), .half_pt(half_pt)
  );

  strobe_gen u_strobe (
    .clk(clk), .clr(clr), .load(load), .half_pt(half_pt),
    .rise_sel(rise_sel), .wclk_q(wclk_q)
  );

  always_ff @(posedge clk) begin
    if (clr)       dout_q <= '0;
    else if (load) dout_q <= win_nxt[FR_W-2:1];
  end

  assign lock_n = ~locked;
  assign dout   = locked ? dout_q : {PAY_W{1'bz}};
  assign wclk   = locked ? wclk_q : 1'bz;
endmodule

// File: rtl/frame_deser_chk.sv
module frame_deser_chk (
  input logic clk,
  input logic rst,
  input logic wake,
  input logic bit_en,
  input logic ser_in,
  input logic rise_sel,
  input logic lock_n,
  input logic wclk_q
);
  // R8
  pdn_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    !wake |=> lock_n);

  // R2
  lock_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_n) |-> ($past(bit_en) && !$past(ser_in)));

  // R9
  lock_needs_bit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lock_n) |-> ($past(bit_en) || !$past(wake)));

  // R7
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && wake && $stable(rise_sel)) |=> $stable(wclk_q));
endmodule

bind frame_deser frame_deser_chk u_chk (
  .clk(clk), .rst(rst), .wake(wake), .bit_en(bit_en), .ser_in(ser_in),
  .rise_sel(rise_sel), .lock_n(lock_n), .wclk_q(wclk_q)
);

// File: tb/tb_frame_deser.sv
`timescale 1ns/1ps
module tb_frame_deser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake = 1'b1;
  logic bit_en = 1'b0;
  logic ser_in = 1'b0;
  logic rise_sel = 1'b1;
  tri1 [9:0] dout_w;
  tri0       wclk_w;
  wire       lock_n;

  int n_chk = 0;
  int n_fail = 0;
  localparam int HIZ = 10'h3FF; // value read through the pull-ups when floating

  always #2.5 clk = ~clk;

  frame_deser dut (
    .clk(clk), .rst(rst), .wake(wake), .bit_en(bit_en), .ser_in(ser_in),
    .rise_sel(rise_sel), .dout(dout_w), .wclk(wclk_w), .lock_n(lock_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_in = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  // Sends the first n bits of a frame: marker, payload LSB first, closing bit.
  // With strb set, the strobe is checked after bit 5 and after bit 6.
  task automatic send_part(input logic st, input logic [9:0] p, input logic sp,
                           input int n, input bit strb, input bit gap);
    logic [11:0] f;
    f = {sp, p, st};
    for (int i = 0; i < n; i++) begin
      if (gap && i == 4) begin
        // R9: enable low, serial input toggles, nothing should move
        for (int g = 0; g < 4; g++) begin
          ser_in = g[0];
          @(negedge clk);
        end
      end
      send_bit(f[i]);
      if (strb && i == 4) chk("R7 strobe still active", wclk_w, rise_sel);
      if (strb && i == 5) chk("R7 strobe returned", wclk_w, !rise_sel);
    end
  endtask

  task automatic send_frame(input logic st, input logic [9:0] p, input logic sp);
    send_part(st, p, sp, 12, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic acquire(input string tag);
    for (int f = 0; f < 7; f++) send_frame(1'b1, 10'h3FF, 1'b0);
    send_part(1'b1, 10'h3FF, 1'b0, 11, 1'b0, 1'b0);
    chk({tag, " not yet locked after 7 frames + 11 bits"}, lock_n, 1);
    send_bit(1'b0);
    chk({tag, " locked on 8th closing bit"}, lock_n, 0);
  endtask

  initial begin
    logic [9:0] p;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R5: reset state
    chk("R5 lock_n after reset", lock_n, 1);
    chk("R5 dout floating after reset", dout_w, HIZ);
    chk("R5 wclk floating after reset", wclk_w, 0);

    // R10: constant input never locks
    for (int i = 0; i < 60; i++) send_bit(1'b0);
    chk("R10 constant zeros", lock_n, 1);
    do_reset();
    for (int i = 0; i < 60; i++) send_bit(1'b1);
    chk("R10 constant ones", lock_n, 1);

    // R8: no acquisition during powerdown
    do_reset();
    wake = 1'b0;
    for (int f = 0; f < 10; f++) send_frame(1'b1, 10'h3FF, 1'b0);
    chk("R8 no lock while powered down", lock_n, 1);
    chk("R8 dout floating while powered down", dout_w, HIZ);
    wake = 1'b1;

    // R2 and R3: lock from every leading offset
    for (int k = 0; k < 12; k++) begin
      do_reset();
      for (int z = 0; z < k; z++) send_bit(1'b0);
      acquire("R3");
      chk("R1 first word after lock", dout_w, 10'h3FF);
      chk("R2 strobe active edge at lock", wclk_w, rise_sel);
    end

    // R1, R7, R9: payload sweep with both strobe polarities
    for (int i = 0; i < 64; i++) begin
      if (i == 32) begin
        rise_sel = 1'b0;
        idle(2);
      end
      p = 10'((i * 173 + 5) & 10'h3FF);
      send_part(1'b1, p, 1'b0, 12, 1'b1, (i % 8) == 3);
      chk("R1 payload", dout_w, p);
      chk("R7 strobe active edge with data", wclk_w, rise_sel);
      if ((i % 8) == 3) chk("R9 word intact across enable gap", dout_w, p);
    end
    rise_sel = 1'b1;
    idle(2);

    // R6 and R4: nonconforming frames while locked
    send_frame(1'b1, 10'h2A5, 1'b0);
    chk("R1 word before violations", dout_w, 10'h2A5);
    send_frame(1'b1, 10'h0F0, 1'b1);
    chk("R6 bad frame holds word", dout_w, 10'h2A5);
    send_frame(1'b0, 10'h00F, 1'b0);
    send_frame(1'b1, 10'h333, 1'b1);
    chk("R4 still locked after 3 bad", lock_n, 0);
    chk("R6 word held over 3 bad", dout_w, 10'h2A5);
    send_frame(1'b1, 10'h111, 1'b0);
    chk("R1 good frame after bad run", dout_w, 10'h111);
    for (int f = 0; f < 3; f++) send_frame(1'b0, 10'h1C7, 1'b1);
    chk("R4 count restarted by good frame", lock_n, 0);
    send_frame(1'b0, 10'h055, 1'b0);
    chk("R4 lock lost after 4 bad", lock_n, 1);
    chk("R5 dout floating after loss", dout_w, HIZ);
    chk("R5 wclk floating after loss", wclk_w, 0);

    // R11: relock after loss
    acquire("R11");
    send_frame(1'b1, 10'h0C3, 1'b0);
    chk("R11 data after relock", dout_w, 10'h0C3);

    // R8: powerdown while locked, then reacquire
    wake = 1'b0;
    idle(1);
    chk("R8 unlock one clock after powerdown", lock_n, 1);
    chk("R8 dout floating in powerdown", dout_w, HIZ);
    wake = 1'b1;
    idle(1);
    acquire("R8");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL R0 watchdog: got %0h expected %0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule